// File: doc/BRIEF.md
# Two-Dimensional Strided Read Streamer

This block reads a rectangular window out of a word-addressed memory and sends it as a single AXI4-Stream packet. One command describes the window: a start address, the number of bytes in each line, the byte pitch from one line's start to the next, and the number of lines. The command also carries the routing destination, stream identifier and user sideband values for the packet. The engine reads each line as consecutive words. It then jumps by the pitch to start the next line, and it repeats until every line has been read. The words leave on the stream in read order. TLAST is set only on the very last word.

The memory port takes one word request per cycle and returns each response a fixed number of cycles later. Every response carries a two-bit code. The engine caps the number of reads in flight so that all returning data fits in its output buffer, which means a stalled stream never drops a word. A command that breaks the alignment or size rules is rejected with an internal error. A slave or decode error on a read response halts the engine. A halted engine takes no further commands until a synchronous reset.

The state machine has four states. IDLE waits for a command. RUN issues reads. DRAIN waits for the last words to leave after all reads are issued. HALT is entered on any error. The transitions are:
- IDLE→RUN when a legal command is accepted.
- IDLE→HALT when an illegal command is accepted.
- RUN→DRAIN on the final read request.
- RUN→HALT or DRAIN→HALT on an error response.
- DRAIN→IDLE when the TLAST word is accepted.
- HALT→HALT always.

Top module: `rect_read_streamer`

## Requirements
- R1: Line k (k counted from 0) is read from byte address start + k·pitch. The words of a line are requested at consecutive addresses, each 4 bytes after the previous one. The pitch minus the line length is skipped between lines.
- R2: Exactly lines·(line bytes / 4) words are streamed for a command, in the order they were requested, each equal to the memory word at its address.
- R3: TLAST is 1 on the final word of the packet and 0 on every other word.
- R4: The destination, identifier and user sideband outputs equal the command's values on every word of the packet.
- R5: cmd_ready is 1 only in IDLE. A command is taken on a cycle where cmd_valid and cmd_ready are both 1.
- R6: A command is illegal in any of these cases: line count zero, line bytes zero, line bytes not a multiple of 4, pitch not a multiple of 4, pitch below the line bytes, or start address not a multiple of 4. An illegal command sets status bit 28, issues no read and halts the engine.
- R7: A response code of 2'b10 sets status bit 29 (slave error) and halts the engine. Codes 2'b00 and 2'b01 are normal data.
- R8: A response code of 2'b11 sets status bit 30 (decode error) and halts the engine.
- R9: While halted, cmd_ready, m_tvalid and rd_req stay 0 until reset.
- R10: Status bit 31 (completed) is set once the TLAST word is accepted. Accepting a legal command clears the whole status word. Status bits 27:0 are always 0.
- R11: Reads in flight plus words buffered never exceed BUF_DEPTH, so the packet arrives intact under any pattern of m_tready.
- R12: After reset, cmd_ready is 1, m_tvalid and rd_req are 0, and the status word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken (idle only) |
| cmd_base | input | ADDR_W | Start byte address |
| cmd_hsize | input | 16 | Bytes per line |
| cmd_stride | input | 16 | Byte pitch between line starts |
| cmd_vsize | input | 13 | Number of lines |
| cmd_dest | input | 5 | Packet destination sideband |
| cmd_id | input | 5 | Packet identifier sideband |
| cmd_user | input | 4 | Packet user sideband |
| rd_req | output | 1 | Memory word read request |
| rd_addr | output | ADDR_W | Byte address of the requested word |
| rd_rvalid | input | 1 | Read response valid |
| rd_rdata | input | DATA_W | Read response data |
| rd_rresp | input | 2 | Response code |
| m_tvalid | output | 1 | Stream word valid |
| m_tready | input | 1 | Stream sink ready |
| m_tdata | output | DATA_W | Stream word |
| m_tlast | output | 1 | Final word of packet |
| m_tdest | output | 5 | Destination sideband |
| m_tid | output | 5 | Identifier sideband |
| m_tuser | output | 4 | User sideband |
| status | output | 32 | Completion and error flags |

## Verification
The bench builds the block with a 32-bit data word (4 bytes per beat) and a four-entry output buffer. Its memory model answers three cycles after each request. With that latency the buffer fills quickly, so the credit limit throttles requests even while the stream is ready. This makes the R11 bound reachable in short runs. The tests cover these cases:
- Windows with gaps and without gaps.
- A one-word packet.
- Steady, random and bursty stalls on m_tready.
- Every illegal-command case.
- Slave and decode errors injected at chosen mid-window addresses.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_HALT  = 2'd3
    } rrs_state_e;

    localparam int HSZ_W  = 16;
    localparam int VSZ_W  = 13;
    localparam int BEAT_W = HSZ_W + VSZ_W;

    localparam int STS_IE  = 28;
    localparam int STS_SE  = 29;
    localparam int STS_DE  = 30;
    localparam int STS_CMP = 31;

    localparam logic [1:0] RESP_SLV = 2'b10;
    localparam logic [1:0] RESP_DEC = 2'b11;

    typedef struct packed {
        logic [4:0] dest;
        logic [4:0] id;
        logic [3:0] user;
    } rrs_side_t;

endpackage

// File: rtl/rrs_cmd_check.sv
module rrs_cmd_check
    import rrs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BPB    = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [HSZ_W-1:0]  hsize,
    input  logic [HSZ_W-1:0]  stride,
    input  logic [VSZ_W-1:0]  vsize,
    output logic              bad,
    output logic [BEAT_W-1:0] beats
);
    localparam int LG = $clog2(BPB);

    logic misaligned;

    generate
        if (LG == 0) begin : g_byte
            assign misaligned = 1'b0;
        end else begin : g_word
            assign misaligned = (base[LG-1:0]   != '0) ||
                                (hsize[LG-1:0]  != '0) ||
                                (stride[LG-1:0] != '0);
        end
    endgenerate

    always_comb begin
        bad   = misaligned || (vsize == '0) || (hsize == '0) || (stride < hsize);
        beats = BEAT_W'(vsize) * BEAT_W'(hsize >> LG);
    end

endmodule

// File: rtl/rrs_walker.sv
module rrs_walker
    import rrs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BPB    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic [HSZ_W-1:0]  hsize,
    input  logic [HSZ_W-1:0]  stride,
    input  logic [VSZ_W-1:0]  vsize,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              final_o
);
    logic [ADDR_W-1:0] line_q;
    logic [HSZ_W-1:0]  col_q;
    logic [HSZ_W-1:0]  hsize_q;
    logic [HSZ_W-1:0]  stride_q;
    logic [VSZ_W-1:0]  left_q;
    logic [HSZ_W:0]    nxt_col;
    logic              end_line;

    always_comb begin
        nxt_col  = {1'b0, col_q} + (HSZ_W+1)'(BPB);
        end_line = (nxt_col == {1'b0, hsize_q});
        addr     = line_q + ADDR_W'(col_q);
        final_o  = end_line && (left_q == VSZ_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q   <= '0;
            col_q    <= '0;
            hsize_q  <= '0;
            stride_q <= '0;
            left_q   <= '0;
        end else if (load) begin
            line_q   <= base;
            col_q    <= '0;
            hsize_q  <= hsize;
            stride_q <= stride;
            left_q   <= vsize;
        end else if (step) begin
            if (end_line) begin
                col_q  <= '0;
                line_q <= line_q + ADDR_W'(stride_q);
                left_q <= left_q - VSZ_W'(1);
            end else begin
                col_q  <= nxt_col[HSZ_W-1:0];
            end
        end
    end

endmodule

// File: rtl/rrs_fifo.sv
module rrs_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic          empty,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;

    assign rdata = mem[rp_q];
    assign empty = (cnt_q == '0);
    assign count = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) begin
                mem[wp_q] <= wdata;
                wp_q      <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + AW'(1);
            end
            if (pop) begin
                rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + AW'(1);
            end
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

    a_r11_no_overflow: assert property (@(posedge clk) disable iff (rst)
        push |-> (cnt_q != CW'(DEPTH)) || pop);

    a_r11_no_underflow: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/rect_read_streamer.sv
module rect_read_streamer
    import rrs_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int BUF_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic [15:0]       cmd_hsize,
    input  logic [15:0]       cmd_stride,
    input  logic [12:0]       cmd_vsize,
    input  logic [4:0]        cmd_dest,
    input  logic [4:0]        cmd_id,
    input  logic [3:0]        cmd_user,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_rvalid,
    input  logic [DATA_W-1:0] rd_rdata,
    input  logic [1:0]        rd_rresp,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tlast,
    output logic [4:0]        m_tdest,
    output logic [4:0]        m_tid,
    output logic [3:0]        m_tuser,
    output logic [31:0]       status
);
    localparam int BPB   = DATA_W / 8;
    localparam int CNT_W = $clog2(BUF_DEPTH + 1);

    rrs_state_e        state_q, state_d;
    rrs_side_t         side_q;
    logic [BEAT_W-1:0] beats_q;
    logic [CNT_W-1:0]  out_q;
    logic [31:0]       status_q;

    logic              cmd_fire, cmd_bad, walk_final, live;
    logic [BEAT_W-1:0] cmd_beats;
    logic [CNT_W-1:0]  fifo_cnt;
    logic [CNT_W:0]    inflight;
    logic              credit_ok, push, pop, fifo_empty, rsp_err, last_fire;

    rrs_cmd_check #(.ADDR_W(ADDR_W), .BPB(BPB)) u_check (
        .base   (cmd_base),
        .hsize  (cmd_hsize),
        .stride (cmd_stride),
        .vsize  (cmd_vsize),
        .bad    (cmd_bad),
        .beats  (cmd_beats)
    );

    rrs_walker #(.ADDR_W(ADDR_W), .BPB(BPB)) u_walk (
        .clk     (clk),
        .rst     (rst),
        .load    (cmd_fire),
        .base    (cmd_base),
        .hsize   (cmd_hsize),
        .stride  (cmd_stride),
        .vsize   (cmd_vsize),
        .step    (rd_req),
        .addr    (rd_addr),
        .final_o (walk_final)
    );

    rrs_fifo #(.W(DATA_W), .DEPTH(BUF_DEPTH)) u_buf (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .wdata (rd_rdata),
        .pop   (pop),
        .rdata (m_tdata),
        .empty (fifo_empty),
        .count (fifo_cnt)
    );

    // handshake and datapath glue
    always_comb begin
        cmd_ready = (state_q == ST_IDLE);
        cmd_fire  = cmd_valid && cmd_ready;
        live      = (state_q == ST_RUN) || (state_q == ST_DRAIN);
        inflight  = {1'b0, out_q} + {1'b0, fifo_cnt};
        credit_ok = inflight < (CNT_W+1)'(BUF_DEPTH);
        rd_req    = (state_q == ST_RUN) && credit_ok;
        rsp_err   = live && rd_rvalid && ((rd_rresp == RESP_SLV) || (rd_rresp == RESP_DEC));
        push      = live && rd_rvalid && !rd_rresp[1];
        m_tvalid  = live && !fifo_empty;
        pop       = m_tvalid && m_tready;
        m_tlast   = (beats_q == BEAT_W'(1));
        last_fire = pop && m_tlast;
        m_tdest   = side_q.dest;
        m_tid     = side_q.id;
        m_tuser   = side_q.user;
        status    = status_q;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cmd_fire) state_d = cmd_bad ? ST_HALT : ST_RUN;
            ST_RUN:   if (rsp_err) state_d = ST_HALT;
                      else if (rd_req && walk_final) state_d = ST_DRAIN;
            ST_DRAIN: if (rsp_err) state_d = ST_HALT;
                      else if (last_fire) state_d = ST_IDLE;
            ST_HALT:  state_d = ST_HALT;
            default:  state_d = ST_HALT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // registered outputs and counters
    always_ff @(posedge clk) begin
        if (rst) begin
            side_q   <= '0;
            beats_q  <= '0;
            out_q    <= '0;
            status_q <= '0;
        end else begin
            out_q <= out_q + CNT_W'(rd_req) - CNT_W'(rd_rvalid);
            if (cmd_fire) begin
                side_q   <= '{dest: cmd_dest, id: cmd_id, user: cmd_user};
                beats_q  <= cmd_beats;
                status_q <= '0;
                status_q[STS_IE] <= cmd_bad;
            end else begin
                if (pop)       beats_q <= beats_q - BEAT_W'(1);
                if (last_fire) status_q[STS_CMP] <= 1'b1;
                if (rsp_err) begin
                    if (rd_rresp[0]) status_q[STS_DE] <= 1'b1;
                    else             status_q[STS_SE] <= 1'b1;
                end
            end
        end
    end

    a_r9_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HALT) |=> (state_q == ST_HALT) && !rd_req && !m_tvalid && !cmd_ready);

    a_r11_credit_bound: assert property (@(posedge clk) disable iff (rst)
        inflight <= (CNT_W+1)'(BUF_DEPTH));

    a_r1_word_aligned: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> (rd_addr % ADDR_W'(BPB)) == '0);

    a_r3_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (m_tvalid && !m_tready) |=> (state_q == ST_HALT) ||
            (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

    a_r10_cmp_after_last: assert property (@(posedge clk) disable iff (rst)
        $rose(status_q[STS_CMP]) |-> $past(last_fire));

    a_r6_bad_halts: assert property (@(posedge clk) disable iff (rst)
        (cmd_fire && cmd_bad) |=> (state_q == ST_HALT) && status_q[STS_IE]);

    a_r4_side_stable: assert property (@(posedge clk) disable iff (rst)
        live && !cmd_fire |=> $stable(side_q));

endmodule

// File: tb/tb_rect_read_streamer.sv
module tb_rect_read_streamer;
    localparam int LAT = 3;

    logic        clk = 0;
    logic        rst = 1;
    logic        cmd_valid = 0;
    logic        cmd_ready;
    logic [31:0] cmd_base = 0;
    logic [15:0] cmd_hsize = 0, cmd_stride = 0;
    logic [12:0] cmd_vsize = 0;
    logic [4:0]  cmd_dest = 0, cmd_id = 0;
    logic [3:0]  cmd_user = 0;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic        rd_rvalid;
    logic [31:0] rd_rdata;
    logic [1:0]  rd_rresp;
    logic        m_tvalid, m_tready = 1, m_tlast;
    logic [31:0] m_tdata;
    logic [4:0]  m_tdest, m_tid;
    logic [3:0]  m_tuser;
    logic [31:0] status;

    always #4 clk = ~clk;

    rect_read_streamer #(.ADDR_W(32), .DATA_W(32), .BUF_DEPTH(4)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_base(cmd_base), .cmd_hsize(cmd_hsize), .cmd_stride(cmd_stride),
        .cmd_vsize(cmd_vsize), .cmd_dest(cmd_dest), .cmd_id(cmd_id), .cmd_user(cmd_user),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
        .rd_rresp(rd_rresp), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
        .m_tlast(m_tlast), .m_tdest(m_tdest), .m_tid(m_tid), .m_tuser(m_tuser),
        .status(status)
    );

    function automatic logic [31:0] memf(input logic [31:0] a);
        return {a[15:0] ^ 16'hC3A5, a[15:0]};
    endfunction

    // memory model: fixed-latency responder
    logic        err_on = 0;
    logic [31:0] err_addr = 0;
    logic [1:0]  err_code = 0;
    logic [LAT-1:0] pv;
    logic [31:0]    pa [LAT];

    always @(posedge clk) begin
        if (rst) pv <= '0;
        else     pv <= {pv[LAT-2:0], rd_req};
        pa[0] <= rd_addr;
        for (int i = 1; i < LAT; i++) pa[i] <= pa[i-1];
    end
    assign rd_rvalid = pv[LAT-1];
    assign rd_rdata  = memf(pa[LAT-1]);
    assign rd_rresp  = (err_on && pa[LAT-1] == err_addr) ? err_code : 2'b00;

    int total = 0, bad = 0;
    bit finished = 0;
    bit halted_exp = 0;
    int bp_mode = 0;
    int cyc = 0;
    logic [31:0] exp_a [$];
    logic [31:0] exp_d [$];
    bit          exp_l [$];
    logic [4:0]  cur_dest, cur_id;
    logic [3:0]  cur_user;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // stream sink readiness pattern
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            case (bp_mode)
                0:       m_tready = 1'b1;
                1:       m_tready = ($urandom % 3) != 0;
                default: m_tready = (cyc % 8) < 2;
            endcase
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (rd_req) begin
                if (halted_exp) check(0, "R9 read while halted", rd_addr, 0);
                else if (exp_a.size() == 0) check(0, "R1 unexpected read", rd_addr, 0);
                else begin
                    logic [31:0] ea;
                    ea = exp_a.pop_front();
                    check(rd_addr == ea, "R1 read address", rd_addr, ea);
                end
            end
            if (m_tvalid && m_tready) begin
                if (exp_d.size() == 0) check(0, "R2 extra beat", m_tdata, 0);
                else begin
                    logic [31:0] ed;
                    bit el;
                    ed = exp_d.pop_front();
                    el = exp_l.pop_front();
                    check(m_tdata == ed, "R2 data (R11)", m_tdata, ed);
                    check(m_tlast == el, "R3 tlast", {31'd0, m_tlast}, {31'd0, el});
                    check({m_tdest, m_tid, m_tuser} == {cur_dest, cur_id, cur_user},
                          "R4 sideband", {18'd0, m_tdest, m_tid, m_tuser},
                          {18'd0, cur_dest, cur_id, cur_user});
                end
            end
        end
    end

    task automatic do_reset();
        rst = 1;
        halted_exp = 0;
        err_on = 0;
        exp_a.delete(); exp_d.delete(); exp_l.delete();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
    endtask

    task automatic run_cmd(input logic [31:0] b, input logic [15:0] h, input logic [15:0] s,
                           input logic [12:0] v, input logic [31:0] exp_sts, input bit good,
                           input string req);
        cur_dest = 5'(b[6:2] ^ 5'h15); cur_id = 5'(h[4:0] + 5'd3); cur_user = v[3:0] ^ 4'h9;
        if (good) begin
            for (int ln = 0; ln < int'(v); ln++)
                for (int c = 0; c < int'(h); c += 4) begin
                    logic [31:0] a;
                    a = b + 32'(ln) * 32'(s) + 32'(c);
                    exp_a.push_back(a);
                    exp_d.push_back(memf(a));
                    exp_l.push_back((ln == int'(v) - 1) && (c == int'(h) - 4));
                end
        end
        @(negedge clk);
        cmd_base = b; cmd_hsize = h; cmd_stride = s; cmd_vsize = v;
        cmd_dest = cur_dest; cmd_id = cur_id; cmd_user = cur_user;
        cmd_valid = 1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 0;
        check(!cmd_ready, "R5 ready low after accept", {31'd0, cmd_ready}, 0);
        if (exp_sts == 32'h1000_0000) begin
            check(status == exp_sts, "R6 internal error flag", status, exp_sts);
        end else begin
            check(status == 0, "R10 status cleared on accept", status, 0);
        end
        for (int k = 0; k < 5000 && !(status[31] || status[30:28] != 0); k++) @(negedge clk);
        check(status == exp_sts, req, status, exp_sts);
        if (status[30:28] != 0) halted_exp = 1;
        if (exp_sts == 32'h8000_0000) begin
            check(exp_d.size() == 0 && exp_a.size() == 0, "R2 all beats delivered",
                  32'(exp_d.size()), 0);
            check(cmd_ready, "R5 ready back in idle", {31'd0, cmd_ready}, 1);
        end
    endtask

    task automatic check_halted(input string req);
        repeat (10) @(negedge clk);
        check(!cmd_ready && !m_tvalid && !rd_req, req,
              {29'd0, cmd_ready, m_tvalid, rd_req}, 0);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            check(0, "watchdog expired", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R12 reset state
        check(cmd_ready && !m_tvalid && !rd_req && status == 0, "R12 reset state",
              {status[31:3], cmd_ready, m_tvalid, rd_req}, 32'h4);

        // R1 window with gaps between lines
        run_cmd(32'h100, 16'd8, 16'd16, 13'd3, 32'h8000_0000, 1, "R10 complete gapped");
        // contiguous lines, bit 31 cleared then set again
        run_cmd(32'h400, 16'd12, 16'd12, 13'd4, 32'h8000_0000, 1, "R10 complete contiguous");
        // single word packet: R3 tlast on the only beat
        run_cmd(32'h800, 16'd4, 16'd4, 13'd1, 32'h8000_0000, 1, "R3 one-beat packet");
        // R11 random backpressure
        bp_mode = 1;
        run_cmd(32'h1000, 16'd32, 16'd100, 13'd20, 32'h8000_0000, 1, "R11 random stalls");
        // R11 bursty backpressure
        bp_mode = 2;
        run_cmd(32'h3000, 16'd16, 16'd64, 13'd9, 32'h8000_0000, 1, "R11 bursty stalls");
        bp_mode = 0;

        // R6 illegal commands
        run_cmd(32'h100, 16'd8, 16'd16, 13'd0, 32'h1000_0000, 0, "R6 zero lines");
        check_halted("R9 halted after bad cmd");
        do_reset();
        run_cmd(32'h100, 16'd6, 16'd16, 13'd2, 32'h1000_0000, 0, "R6 line bytes not word multiple");
        do_reset();
        run_cmd(32'h100, 16'd16, 16'd8, 13'd2, 32'h1000_0000, 0, "R6 pitch below line");
        do_reset();
        run_cmd(32'h102, 16'd8, 16'd16, 13'd2, 32'h1000_0000, 0, "R6 unaligned start");
        do_reset();
        run_cmd(32'h100, 16'd8, 16'd18, 13'd2, 32'h1000_0000, 0, "R6 unaligned pitch");
        do_reset();
        run_cmd(32'h100, 16'd0, 16'd16, 13'd2, 32'h1000_0000, 0, "R6 zero line bytes");
        do_reset();
        check(cmd_ready && status == 0, "R12 state after reset from halt",
              status, 0);

        // R7 slave error mid-window
        err_on = 1; err_addr = 32'h220; err_code = 2'b10;
        run_cmd(32'h200, 16'd8, 16'd16, 13'd4, 32'h2000_0000, 1, "R7 slave error flag");
        check_halted("R9 halted after slave error");
        do_reset();

        // R8 decode error mid-window
        err_on = 1; err_addr = 32'h538; err_code = 2'b11;
        run_cmd(32'h500, 16'd16, 16'd24, 13'd5, 32'h4000_0000, 1, "R8 decode error flag");
        check_halted("R9 halted after decode error");
        do_reset();

        // code 01 counts as normal data (R7)
        err_on = 1; err_addr = 32'h604; err_code = 2'b01;
        run_cmd(32'h600, 16'd8, 16'd8, 13'd2, 32'h8000_0000, 1, "R7 code 01 treated as data");
        err_on = 0;

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule